// File: doc/BRIEF.md
# SPI Master Channel Transfer Engine

This block is a single channel of a multichannel SPI master. It holds the channel's transmit word, received word, configuration word, three status flags and an enable bit, and it decides when a serial exchange may begin. Software, or a bus decoder in front of the block, loads transmit words, reads received words and changes the configuration. The engine then hands words to an external serial shifter through a start/done handshake and keeps its flags up to date.

A direction mode field and a turbo bit decide which flags stop a new exchange and which flags a finished exchange raises. Two DMA request outputs follow the flags, the enable bit and their own enable bits in the configuration. When a module-wide single-channel input is set and the channel's force bit is clear, an evaluation that passes completes the transfer bookkeeping without calling the shifter.

Top module: `spi_chan_engine`

## Requirements
- R1: After reset the status is 3'b010 (only transmit-empty set), the configuration reads 23'h060000, the channel is disabled, no exchange is running and both DMA requests are low.
- R2: A configuration write keeps bits 22:0 of the written word. The field layout is: direction mode in bits 13:12 (0 both directions, 1 receive-only, 2 transmit-only, 3 treated as both), write-DMA enable in bit 14, read-DMA enable in bit 15, turbo in bit 19, force in bit 20, and word length minus one in bits 11:7. The shifter receives the word length (field plus one) on shf_len.
- R3: Status bit 0 is receive-full, bit 1 is transmit-empty and bit 2 is end-of-transfer. End-of-transfer stays set once raised, until reset.
- R4: An evaluation starts nothing when the channel is disabled. It also starts nothing when receive-full is set, the mode is not transmit-only and turbo is clear. It also starts nothing when transmit-empty is set and the mode is not receive-only.
- R5: Loading the transmit register clears transmit-empty. Reading the received word (rx_rd) clears receive-full. Each of these events, and a 0-to-1 change of the enable bit, requests an evaluation. The evaluation runs in the next cycle in which no exchange is in flight. Writing 1 to an enable that is already 1 requests nothing.
- R6: A passing evaluation pulses shf_start for one cycle with the transmit word, but only when single_mode is low or force is set. At most one exchange is in flight: shf_start never rises while an earlier exchange awaits shf_done.
- R7: A transfer completes on shf_done, or in the evaluation cycle itself when the shifter is bypassed. On completion the transmit register becomes 0, end-of-transfer and transmit-empty are set, and receive-full is set unless the mode is transmit-only. The received word takes shf_rx only on a shifter completion.
- R8: dma_wr_req is high exactly when the channel is enabled, write-DMA enable is set, transmit-empty is set and the mode is not receive-only.
- R9: dma_rd_req is high exactly when the channel is enabled, read-DMA enable is set, receive-full is set and the mode is not transmit-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_o | output | 23 | Current configuration word |
| en_wr | input | 1 | Enable write strobe |
| en_wdata | input | 1 | Enable value to write |
| en_o | output | 1 | Current enable bit |
| single_mode | input | 1 | Module single-channel mode |
| tx_wr | input | 1 | Transmit register load strobe |
| tx_wdata | input | DATA_W | Transmit word to load |
| tx_o | output | DATA_W | Current transmit register |
| rx_rd | input | 1 | Received-word read strobe |
| rx_o | output | DATA_W | Current received word |
| status_o | output | 3 | {end-of-transfer, transmit-empty, receive-full} |
| dma_wr_req | output | 1 | Write DMA request |
| dma_rd_req | output | 1 | Read DMA request |
| shf_start | output | 1 | One-cycle exchange start to the shifter |
| shf_tx | output | DATA_W | Word handed to the shifter |
| shf_len | output | 6 | Word length for the exchange |
| shf_done | input | 1 | Shifter completion pulse |
| shf_rx | input | DATA_W | Word returned by the shifter |

## Verification
The embedded properties watch, on every cycle, that a start pulse appears only while the channel is enabled and no exchange is outstanding. They also check that a load or a read clears its flag in the following cycle and that a shifter completion leaves the transmit register empty with the end-of-transfer flag raised. The interplay of mode, turbo, force and single-channel mode can only be shown by the scenarios. These cover which evaluations actually start an exchange, which are bypassed, what the received word becomes and how the DMA requests follow. The bench sweeps every combination of those four controls through enable, two loads, a read and a disable.

// File: rtl/spi_chan_pkg.sv
package spi_chan_pkg;
   localparam int CFG_W        = 23;
   localparam logic [CFG_W-1:0] CFG_RST = 23'h060000;
   localparam int LEN_W        = 6;

   localparam int B_WL_LO      = 7;
   localparam int B_MODE_LO    = 12;
   localparam int B_DMAW       = 14;
   localparam int B_DMAR       = 15;
   localparam int B_TURBO      = 19;
   localparam int B_FORCE      = 20;

   localparam int ST_RXF       = 0;
   localparam int ST_TXE       = 1;
   localparam int ST_EOT       = 2;
   localparam logic [2:0] ST_RST = 3'b010;

   typedef enum logic [1:0] {
      DIR_BOTH = 2'd0,
      DIR_RX   = 2'd1,
      DIR_TX   = 2'd2,
      DIR_BAD  = 2'd3
   } dir_t;

   typedef struct packed {
      dir_t       dir;
      logic       turbo;
      logic       frc;
      logic       dmaw_en;
      logic       dmar_en;
      logic [4:0] wl_m1;
   } chan_cfg_t;
endpackage

// File: rtl/spi_chan_cfg.sv
module spi_chan_cfg
   import spi_chan_pkg::*;
#(
   parameter int BUS_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [BUS_W-1:0] wdata,
   output logic [CFG_W-1:0] cfg_q,
   output chan_cfg_t        fields
);
   if (BUS_W < CFG_W) begin : g_bad_bus
      $error("spi_chan_cfg: BUS_W must cover the configuration word");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  cfg_q <= CFG_RST;
      else if (wr) cfg_q <= wdata[CFG_W-1:0];
   end

   always_comb begin
      fields.dir     = dir_t'(cfg_q[B_MODE_LO +: 2]);
      fields.turbo   = cfg_q[B_TURBO];
      fields.frc     = cfg_q[B_FORCE];
      fields.dmaw_en = cfg_q[B_DMAW];
      fields.dmar_en = cfg_q[B_DMAR];
      fields.wl_m1   = cfg_q[B_WL_LO +: 5];
   end
endmodule

// File: rtl/spi_chan_ctrl.sv
module spi_chan_ctrl
   import spi_chan_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  chan_cfg_t         fields,
   input  logic              en,
   input  logic              en_rise,
   input  logic              single_mode,
   input  logic              tx_wr,
   input  logic [DATA_W-1:0] tx_wdata,
   input  logic              rx_rd,
   input  logic              shf_done,
   input  logic [DATA_W-1:0] shf_rx,
   output logic [2:0]        status,
   output logic [DATA_W-1:0] tx_q,
   output logic [DATA_W-1:0] rx_q,
   output logic              shf_start,
   output logic [DATA_W-1:0] shf_tx,
   output logic [LEN_W-1:0]  shf_len
);
   logic pend, busy;
   logic eval, blocked, go, use_shifter, fin_bypass, fin_shift, fin;
   logic rxf, txe;

   assign rxf = status[ST_RXF];
   assign txe = status[ST_TXE];

   always_comb begin
      eval        = pend && !busy;
      blocked     = !en
                  || (rxf && fields.dir != DIR_TX && !fields.turbo)
                  || (txe && fields.dir != DIR_RX);
      go          = eval && !blocked;
      use_shifter = !single_mode || fields.frc;
      fin_bypass  = go && !use_shifter;
      fin_shift   = busy && shf_done;
      fin         = fin_bypass || fin_shift;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend <= 1'b0;
      end else if (tx_wr || rx_rd || en_rise) begin
         pend <= 1'b1;
      end else if (eval) begin
         pend <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         shf_start <= 1'b0;
         shf_tx    <= '0;
         shf_len   <= '0;
      end else begin
         shf_start <= go && use_shifter;
         if (go && use_shifter) begin
            busy    <= 1'b1;
            shf_tx  <= tx_q;
            shf_len <= LEN_W'(fields.wl_m1) + LEN_W'(1);
         end else if (fin_shift) begin
            busy    <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status <= ST_RST;
         tx_q   <= '0;
         rx_q   <= '0;
      end else begin
         if (fin) begin
            status[ST_EOT] <= 1'b1;
            status[ST_TXE] <= 1'b1;
            tx_q           <= '0;
            if (fields.dir != DIR_TX) status[ST_RXF] <= 1'b1;
         end
         if (fin_shift) rx_q <= shf_rx;
         if (tx_wr) begin
            tx_q           <= tx_wdata;
            status[ST_TXE] <= 1'b0;
         end
         if (rx_rd) status[ST_RXF] <= 1'b0;
      end
   end

   a_r6_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
      shf_start |-> !$past(busy));
   a_r4_start_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      shf_start |-> $past(en));
   a_r5_txload_clears: assert property (@(posedge clk) disable iff (!rst_n)
      tx_wr |=> !status[ST_TXE]);
   a_r5_rxread_clears: assert property (@(posedge clk) disable iff (!rst_n)
      rx_rd |=> !status[ST_RXF]);
   a_r7_done_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && shf_done && !tx_wr) |=> (status[ST_TXE] && status[ST_EOT] && tx_q == '0));
   a_r3_eot_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      status[ST_EOT] |=> status[ST_EOT]);
endmodule

// File: rtl/spi_chan_dma.sv
module spi_chan_dma
   import spi_chan_pkg::*;
#(
   parameter bit REG_OUT = 1'b0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      en,
   input  chan_cfg_t fields,
   input  logic [2:0] status,
   output logic      wr_req,
   output logic      rd_req
);
   logic wr_c, rd_c;

   always_comb begin
      wr_c = en && fields.dmaw_en && status[ST_TXE] && fields.dir != DIR_RX;
      rd_c = en && fields.dmar_en && status[ST_RXF] && fields.dir != DIR_TX;
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            wr_req <= 1'b0;
            rd_req <= 1'b0;
         end else begin
            wr_req <= wr_c;
            rd_req <= rd_c;
         end
      end
   end else begin : g_comb
      assign wr_req = wr_c;
      assign rd_req = rd_c;
   end
endmodule

// File: rtl/spi_chan_engine.sv
module spi_chan_engine
   import spi_chan_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int BUS_W   = 32,
   parameter bit DMA_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [BUS_W-1:0]  cfg_wdata,
   output logic [CFG_W-1:0]  cfg_o,
   input  logic              en_wr,
   input  logic              en_wdata,
   output logic              en_o,
   input  logic              single_mode,
   input  logic              tx_wr,
   input  logic [DATA_W-1:0] tx_wdata,
   output logic [DATA_W-1:0] tx_o,
   input  logic              rx_rd,
   output logic [DATA_W-1:0] rx_o,
   output logic [2:0]        status_o,
   output logic              dma_wr_req,
   output logic              dma_rd_req,
   output logic              shf_start,
   output logic [DATA_W-1:0] shf_tx,
   output logic [LEN_W-1:0]  shf_len,
   input  logic              shf_done,
   input  logic [DATA_W-1:0] shf_rx
);
   if (DATA_W < 4 || DATA_W > 32) begin : g_bad_width
      $error("spi_chan_engine: DATA_W must lie in 4..32");
   end

   chan_cfg_t fields;
   logic      en_q, en_rise;

   always_ff @(posedge clk) begin
      if (!rst_n)     en_q <= 1'b0;
      else if (en_wr) en_q <= en_wdata;
   end
   assign en_rise = en_wr && en_wdata && !en_q;
   assign en_o    = en_q;

   spi_chan_cfg #(.BUS_W(BUS_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(cfg_wdata),
      .cfg_q(cfg_o), .fields(fields)
   );

   spi_chan_ctrl #(.DATA_W(DATA_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .fields(fields), .en(en_q), .en_rise(en_rise),
      .single_mode(single_mode), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
      .rx_rd(rx_rd), .shf_done(shf_done), .shf_rx(shf_rx),
      .status(status_o), .tx_q(tx_o), .rx_q(rx_o),
      .shf_start(shf_start), .shf_tx(shf_tx), .shf_len(shf_len)
   );

   spi_chan_dma #(.REG_OUT(DMA_REG)) u_dma (
      .clk(clk), .rst_n(rst_n), .en(en_q), .fields(fields), .status(status_o),
      .wr_req(dma_wr_req), .rd_req(dma_rd_req)
   );

   a_r1_reset_state: assert property (@(posedge clk)
      $past(!rst_n) |-> (status_o == ST_RST && !en_o && !shf_start));
   a_r2_cfg_width: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> cfg_o == $past(cfg_wdata[CFG_W-1:0]));
endmodule

// File: tb/sim_spi_chan_engine.sv
`timescale 1ns/1ps
module sim_spi_chan_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [22:0] cfg_o;
   logic        en_wr = 1'b0, en_wdata = 1'b0, en_o;
   logic        single_mode = 1'b0;
   logic        tx_wr = 1'b0;
   logic [31:0] tx_wdata = '0, tx_o, rx_o, shf_tx, shf_rx = '0;
   logic        rx_rd = 1'b0;
   logic [2:0]  status_o;
   logic        dma_wr_req, dma_rd_req, shf_start, shf_done = 1'b0;
   logic [5:0]  shf_len;

   int n_chk = 0, n_err = 0, n_start = 0;
   bit done_flag = 0;

   always #2 clk = ~clk;

   spi_chan_engine u0 (.*);

   // shifter model: answers 3 cycles after a start
   initial begin
      int cnt = 0;
      logic [31:0] w = '0;
      logic [5:0]  l = '0;
      forever begin
         @(negedge clk);
         shf_done = 1'b0;
         if (shf_start) begin
            cnt = 3; w = shf_tx; l = shf_len; n_start++;
         end else if (cnt > 0) begin
            cnt--;
            if (cnt == 0) begin
               shf_done = 1'b1;
               shf_rx   = ~w ^ {26'b0, l};
            end
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // reference state
   int  m_mode; bit m_turbo, m_frc, m_single, m_en;
   bit  m_rxf, m_txe, m_eot; logic [31:0] m_tx, m_rx; int m_starts;

   function automatic void m_eval();
      if (!m_en) return;
      if (m_rxf && m_mode != 2 && !m_turbo) return;
      if (m_txe && m_mode != 1) return;
      if (!m_single || m_frc) begin
         m_rx = ~m_tx ^ 32'd8;
         m_starts++;
      end
      m_tx = '0; m_eot = 1; m_txe = 1;
      if (m_mode != 2) m_rxf = 1;
   endfunction

   task automatic settle_and_check();
      repeat (12) @(negedge clk);
      chk("R3/R4/R7 status", {29'b0, status_o}, {29'b0, m_eot, m_txe, m_rxf});
      chk("R7 rx word", rx_o, m_rx);
      chk("R7 tx reg", tx_o, m_tx);
      chk("R6 start count", n_start, m_starts);
      chk("R8 write dma", {31'b0, dma_wr_req}, {31'b0, m_en && m_txe && m_mode != 1});
      chk("R9 read dma", {31'b0, dma_rd_req}, {31'b0, m_en && m_rxf && m_mode != 2});
   endtask

   task automatic pulse_en(input bit v);
      @(negedge clk); en_wr = 1; en_wdata = v;
      @(negedge clk); en_wr = 0;
      if (v && !m_en) begin m_en = 1; m_eval(); end
      else m_en = v;
   endtask

   task automatic load_tx(input logic [31:0] v);
      @(negedge clk); tx_wr = 1; tx_wdata = v;
      @(negedge clk); tx_wr = 0;
      m_tx = v; m_txe = 0; m_eval();
   endtask

   task automatic read_rx();
      @(negedge clk); rx_rd = 1;
      @(negedge clk); rx_rd = 0;
      m_rxf = 0; m_eval();
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 0;
      repeat (2) @(negedge clk); rst_n = 1;
      m_en = 0; m_rxf = 0; m_txe = 1; m_eot = 0; m_tx = '0; m_rx = '0;
      m_starts = n_start;
   endtask

   initial begin
      do_reset();
      chk("R1 status", {29'b0, status_o}, 32'h2);
      chk("R1 cfg", {9'b0, cfg_o}, 32'h060000);
      chk("R1 dma", {30'b0, dma_wr_req, dma_rd_req}, 32'h0);
      chk("R1 enable", {31'b0, en_o}, 32'h0);
      @(negedge clk); cfg_wr = 1; cfg_wdata = 32'hFFFF_FFFF;
      @(negedge clk); cfg_wr = 0;
      chk("R2 cfg mask", {9'b0, cfg_o}, 32'h007F_FFFF);
      for (int md = 0; md < 3; md++)
         for (int tb = 0; tb < 2; tb++)
            for (int fr = 0; fr < 2; fr++)
               for (int sg = 0; sg < 2; sg++) begin
                  do_reset();
                  m_mode = md; m_turbo = tb[0]; m_frc = fr[0]; m_single = sg[0];
                  single_mode = sg[0];
                  @(negedge clk); cfg_wr = 1;
                  cfg_wdata = (32'(fr) << 20) | (32'(tb) << 19) | (32'h3 << 14)
                            | (32'(md) << 12) | (32'd7 << 7);
                  @(negedge clk); cfg_wr = 0;
                  pulse_en(1);            settle_and_check();
                  pulse_en(1);            settle_and_check();   // R5 no second rise
                  load_tx(32'hA5C3_0F10 + md); settle_and_check();
                  load_tx(32'h1234_5678 ^ tb); settle_and_check();
                  read_rx();              settle_and_check();
                  if (!sg[0] || fr[0]) chk("R2 length", {26'b0, shf_len}, 32'd8);
                  pulse_en(0);            settle_and_check();
               end
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done_flag) begin
         n_chk++; n_err++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule